// File: doc/BRIEF.md
# Four-Level Bus Grant Arbiter

This block is the central arbiter that sits at the head of a backplane grant chain. It watches four active-low request levels and the shared active-low busy line, and it answers by pulling one of four active-low grant lines low. These grant lines drive the grant inputs of the first slot. Requesters further down the chain are outside this block. The block never takes the bus away from an owner. It hands out a new grant only while the bus is free, and it withdraws the grant as soon as the winner pulls busy low.

A build-time parameter selects one of three arbitration options. The fixed-priority option always favours the highest-numbered requesting level, and it raises a bus-clear warning to the current owner when a more important level starts waiting. The round-robin option scans downward from the level that won last, wraps from level 0 to level 3, and never raises bus-clear. The single-level option serves only level 3. Every input is sampled on the rising clock edge, and every output comes from a register, so a decision made from the inputs at edge k shows at the outputs just after edge k.

Top module: `grant_chain_arbiter`

## Requirements
- R1: While `rst_n` is low, all four `grant_n` bits and `clear_n` are high. After reset the round-robin position is level 3, so the first round-robin scan tests levels 2, 1, 0 and then 3.
- R2: In fixed-priority mode (MODE = ARB_FIXED), a new grant goes to the highest-numbered level whose request is low. Bit i of `req_n` and of `grant_n` stands for level i.
- R3: In fixed-priority mode, `clear_n` is low in the cycle after an edge at which `busy_n` was low and some level numbered above the last granted level was requesting. Otherwise `clear_n` is high.
- R4: In round-robin mode (MODE = ARB_ROUND), a new grant goes to the first requesting level in the order p-1, p-2, and so on, wrapping from level 0 to level 3. Here p is the last granted level, and level p itself is tested last.
- R5: In round-robin mode and in single-level mode, `clear_n` stays high at all times.
- R6: In single-level mode (MODE = ARB_SINGLE), only `grant_n[3]` is ever driven low. Requests on levels 0 to 2 produce no grant.
- R7: No new grant appears at an edge where `busy_n` is low.
- R8: A grant that is held when `busy_n` is sampled low is withdrawn at that edge. At most one `grant_n` bit is low at any time.
- R9: A held grant is withdrawn at the first edge where its own level no longer requests, even if the bus was never taken.
- R10: When no grant is held, `busy_n` is high and an eligible request exists at an edge, the grant appears right after that edge.
- R11: With no requests pending, no grant is issued and the round-robin position stays where it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| req_n | input | 4 | Request levels 0..3, active low |
| busy_n | input | 1 | Shared bus-busy line, active low |
| grant_n | output | 4 | Grant for levels 0..3, active low, feeds the first slot |
| clear_n | output | 1 | Bus-clear to the current owner, active low (fixed-priority mode only) |

## Verification
Two functions can fall on the same edge: the bus-clear output and the issue of a new grant. Both depend on the busy line and the pending requests sampled at one edge. The bench holds a higher-level request while busy is low, so that bus-clear goes low. It then releases busy without touching the requests. At that single edge, bus-clear must return high and the waiting level must receive its grant. On the next edge the new owner takes busy while its own level still requests, and bus-clear must stay high, because a request at the owner's own level is not a higher one. All three modes share the same stimulus, so the bench can also confirm that the round-robin and single-level instances keep bus-clear high throughout that sequence.

// File: rtl/arb_pkg.sv
package arb_pkg;

  localparam int ARB_LEVELS = 4;
  localparam int ARB_IDX_W  = $clog2(ARB_LEVELS);

  typedef enum logic [1:0] {
    ARB_FIXED  = 2'd0,
    ARB_ROUND  = 2'd1,
    ARB_SINGLE = 2'd2
  } arb_mode_e;

  typedef logic [ARB_LEVELS-1:0] lvl_vec_t;
  typedef logic [ARB_IDX_W-1:0]  lvl_idx_t;

  typedef struct packed {
    logic     hit;
    lvl_idx_t idx;
  } pick_t;

  // Highest-numbered set bit wins.
  function automatic pick_t pick_highest(lvl_vec_t req);
    pick_t r;
    r = '0;
    for (int i = 0; i < ARB_LEVELS; i++) begin
      if (req[i]) begin
        r.hit = 1'b1;
        r.idx = lvl_idx_t'(i);
      end
    end
    return r;
  endfunction

  // Downward scan from ptr-1, wrapping, with ptr itself tested last.
  // The loop walks from the farthest candidate to the nearest, so the
  // last hit written is the nearest one.
  function automatic pick_t pick_below(lvl_vec_t req, lvl_idx_t ptr);
    pick_t r;
    r = '0;
    for (int k = ARB_LEVELS; k >= 1; k--) begin
      int c;
      c = (int'(ptr) + ARB_LEVELS - k) % ARB_LEVELS;
      if (req[c]) begin
        r.hit = 1'b1;
        r.idx = lvl_idx_t'(c);
      end
    end
    return r;
  endfunction

  function automatic lvl_vec_t level_bit(lvl_idx_t idx);
    return lvl_vec_t'(1) << idx;
  endfunction

  function automatic logic any_above(lvl_vec_t req, lvl_idx_t idx);
    logic a;
    a = 1'b0;
    for (int i = 0; i < ARB_LEVELS; i++) begin
      if (req[i] && (i > int'(idx))) a = 1'b1;
    end
    return a;
  endfunction

endpackage

// File: rtl/arb_req_qual.sv
module arb_req_qual
  import arb_pkg::*;
#(
  parameter arb_mode_e MODE = ARB_FIXED
) (
  input  lvl_vec_t req_n,
  output lvl_vec_t req
);

  // Single-level mode listens only to the top level.
  localparam lvl_vec_t LEVEL_MASK =
    (MODE == ARB_SINGLE) ? level_bit(lvl_idx_t'(ARB_LEVELS-1)) : '1;

  for (genvar i = 0; i < ARB_LEVELS; i++) begin : g_lvl
    assign req[i] = ~req_n[i] & LEVEL_MASK[i];
  end

endmodule

// File: rtl/arb_selector.sv
module arb_selector
  import arb_pkg::*;
#(
  parameter arb_mode_e MODE = ARB_FIXED
) (
  input  lvl_vec_t req,
  input  lvl_idx_t ptr,
  output pick_t    pick
);

  always_comb begin
    unique case (MODE)
      ARB_ROUND: pick = pick_below(req, ptr);
      default:   pick = pick_highest(req);
    endcase
  end

endmodule

// File: rtl/arb_grant_ctl.sv
module arb_grant_ctl
  import arb_pkg::*;
#(
  parameter lvl_idx_t PTR_INIT = lvl_idx_t'(ARB_LEVELS-1)
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     busy_n,
  input  lvl_vec_t req,
  input  pick_t    pick,
  output lvl_vec_t gnt,
  output lvl_idx_t owner,
  output logic     owner_vld,
  output lvl_idx_t ptr
);

  logic held;
  logic own_still_req;
  logic drop_ev;
  logic issue_ev;

  assign held          = |gnt;
  assign own_still_req = |(gnt & req);
  assign drop_ev       = held && (!busy_n || !own_still_req);
  assign issue_ev      = !held && busy_n && pick.hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt       <= '0;
      owner     <= PTR_INIT;
      owner_vld <= 1'b0;
      ptr       <= PTR_INIT;
    end else if (drop_ev) begin
      gnt <= '0;
    end else if (issue_ev) begin
      gnt       <= level_bit(pick.idx);
      owner     <= pick.idx;
      owner_vld <= 1'b1;
      ptr       <= pick.idx;
    end
  end

endmodule

// File: rtl/arb_clear_gen.sv
module arb_clear_gen
  import arb_pkg::*;
#(
  parameter arb_mode_e MODE = ARB_FIXED
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     busy_n,
  input  lvl_vec_t req,
  input  lvl_idx_t owner,
  input  logic     owner_vld,
  output logic     clear
);

  logic higher_waiting;

  assign higher_waiting = owner_vld && any_above(req, owner);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clear <= 1'b0;
    end else if (MODE == ARB_FIXED) begin
      clear <= !busy_n && higher_waiting;
    end else begin
      clear <= 1'b0;
    end
  end

endmodule

// File: rtl/grant_chain_arbiter.sv
module grant_chain_arbiter
  import arb_pkg::*;
#(
  parameter arb_mode_e MODE = ARB_FIXED
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ARB_LEVELS-1:0] req_n,
  input  logic                  busy_n,
  output logic [ARB_LEVELS-1:0] grant_n,
  output logic                  clear_n
);

  lvl_vec_t req_q;
  pick_t    pick_w;
  lvl_vec_t gnt_w;
  lvl_idx_t owner_w;
  logic     owner_vld_w;
  lvl_idx_t ptr_w;
  logic     clear_w;

  arb_req_qual #(.MODE(MODE)) u_qual (
    .req_n (req_n),
    .req   (req_q)
  );

  arb_selector #(.MODE(MODE)) u_sel (
    .req  (req_q),
    .ptr  (ptr_w),
    .pick (pick_w)
  );

  arb_grant_ctl u_gctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy_n    (busy_n),
    .req       (req_q),
    .pick      (pick_w),
    .gnt       (gnt_w),
    .owner     (owner_w),
    .owner_vld (owner_vld_w),
    .ptr       (ptr_w)
  );

  arb_clear_gen #(.MODE(MODE)) u_clr (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy_n    (busy_n),
    .req       (req_q),
    .owner     (owner_w),
    .owner_vld (owner_vld_w),
    .clear     (clear_w)
  );

  assign grant_n = ~gnt_w;
  assign clear_n = ~clear_w;

endmodule

// File: rtl/arb_checker.sv
module arb_checker
  import arb_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic [ARB_LEVELS-1:0] req_n,
  input logic                  busy_n,
  input logic [ARB_LEVELS-1:0] grant_n,
  input logic                  clear_n,
  input arb_mode_e             mode_code
);

  localparam logic [ARB_LEVELS-1:0] NONE = '1;

  // R8: never more than one grant low
  a_r8_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~grant_n));

  // R8: a held grant goes away once busy is seen low
  a_r8_withdraw: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_n && grant_n != NONE) |=> (grant_n == NONE));

  // R7: nothing new is granted while busy is low
  a_r7_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_n && grant_n == NONE) |=> (grant_n == NONE));

  // R6: single-level mode touches only the top grant
  a_r6_top_only: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == ARB_SINGLE) |-> (grant_n[ARB_LEVELS-2:0] == '1));

  // R5: bus-clear idle outside fixed-priority mode
  a_r5_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code != ARB_FIXED) |-> clear_n);

  // R3: bus-clear only follows a busy sample
  a_r3_clear_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_n) |-> $past(!busy_n));

  // R10: free bus with a pending request gets a grant on the next edge
  a_r10_prompt: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code != ARB_SINGLE && busy_n && grant_n == NONE && req_n != NONE)
      |=> (grant_n != NONE));

  // R2: a fresh fixed-priority grant is the top requester of the prior edge
  a_r2_highest: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == ARB_FIXED && $past(grant_n) == NONE && grant_n != NONE)
      |-> ((((~$past(req_n)) & (~grant_n)) != '0) &&
           ({1'b0, ~$past(req_n)} < {~grant_n, 1'b0})));

endmodule

bind grant_chain_arbiter arb_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_n     (req_n),
  .busy_n    (busy_n),
  .grant_n   (grant_n),
  .clear_n   (clear_n),
  .mode_code (MODE)
);

// File: tb/sim_grant_chain_arbiter.sv
module sim_grant_chain_arbiter;
  import arb_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req_n = 4'hF;
  logic       busy_n = 1'b1;
  logic [3:0] g_fix, g_rr, g_one;
  logic       c_fix, c_rr, c_one;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  grant_chain_arbiter #(.MODE(ARB_FIXED)) u0 (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .busy_n(busy_n),
    .grant_n(g_fix), .clear_n(c_fix));
  grant_chain_arbiter #(.MODE(ARB_ROUND)) u1 (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .busy_n(busy_n),
    .grant_n(g_rr), .clear_n(c_rr));
  grant_chain_arbiter #(.MODE(ARB_SINGLE)) u2 (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .busy_n(busy_n),
    .grant_n(g_one), .clear_n(c_one));

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic [3:0] r, input logic b);
    req_n  = r;
    busy_n = b;
    step();
  endtask

  task automatic chk_all(input string tag, input logic [3:0] ef, input logic [3:0] er,
                         input logic [3:0] eo);
    chk({tag, " fixed"}, g_fix, ef);
    chk({tag, " round"}, g_rr, er);
    chk({tag, " single"}, g_one, eo);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req_n = 4'hF; busy_n = 1'b1;
    repeat (3) step();
    chk_all("R1 reset grants", 4'hF, 4'hF, 4'hF);
    chk("R1 reset clear", {3'b0, c_fix & c_rr & c_one}, 4'h1);
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_grant_rotate();
    drive(4'b0101, 1'b1);
    chk_all("R2 R4 R6 R10 first grant", 4'b0111, 4'b1101, 4'b0111);
    drive(4'b0101, 1'b0);
    chk_all("R8 withdraw on busy", 4'hF, 4'hF, 4'hF);
    chk("R3 no higher pending", {3'b0, c_fix}, 4'h1);
    drive(4'b0101, 1'b0);
    chk_all("R7 no grant while busy", 4'hF, 4'hF, 4'hF);
    drive(4'b0101, 1'b1);
    chk_all("R4 wrap 0 to 3", 4'b0111, 4'b0111, 4'b0111);
    drive(4'b0101, 1'b0);
    chk_all("R8 withdraw again", 4'hF, 4'hF, 4'hF);
    drive(4'b0101, 1'b1);
    chk_all("R4 step down from 3", 4'b0111, 4'b1101, 4'b0111);
    drive(4'b0101, 1'b0);
  endtask

  task automatic t_bus_clear();
    drive(4'b1110, 1'b1);
    chk_all("R2 R4 R6 level0 only", 4'b1110, 4'b1110, 4'hF);
    drive(4'hF, 1'b0);
    chk("R3 clear idle", {3'b0, c_fix}, 4'h1);
    drive(4'b1011, 1'b0);
    chk("R3 clear raised", {3'b0, c_fix}, 4'h0);
    chk("R5 round clear", {3'b0, c_rr}, 4'h1);
    chk("R5 single clear", {3'b0, c_one}, 4'h1);
    chk_all("R7 clear but no grant", 4'hF, 4'hF, 4'hF);
    drive(4'hF, 1'b0);
    chk("R3 clear drops with request", {3'b0, c_fix}, 4'h1);
    drive(4'b1011, 1'b0);
    chk("R3 clear raised again", {3'b0, c_fix}, 4'h0);
    // busy released with the higher request still present: both on one edge
    drive(4'b1011, 1'b1);
    chk("R3 clear released", {3'b0, c_fix}, 4'h1);
    chk_all("R2 R4 R6 grant on release", 4'b1011, 4'b1011, 4'hF);
    drive(4'b1011, 1'b0);
    chk("R3 same level not higher", {3'b0, c_fix}, 4'h1);
    chk_all("R8 withdraw level2", 4'hF, 4'hF, 4'hF);
  endtask

  task automatic t_drop_idle();
    drive(4'hF, 1'b1);
    chk_all("R11 no request", 4'hF, 4'hF, 4'hF);
    drive(4'b0111, 1'b1);
    chk_all("R4 R6 level3", 4'b0111, 4'b0111, 4'b0111);
    drive(4'hF, 1'b1);
    chk_all("R9 request withdrawn", 4'hF, 4'hF, 4'hF);
    drive(4'hF, 1'b1);
    drive(4'hF, 1'b1);
    chk_all("R11 idle stays empty", 4'hF, 4'hF, 4'hF);
    drive(4'b1001, 1'b1);
    chk_all("R2 R11 pointer held at 3", 4'b1011, 4'b1011, 4'hF);
    drive(4'hF, 1'b1);
    chk_all("R9 drop level2", 4'hF, 4'hF, 4'hF);
  endtask

  task automatic t_reset_pointer();
    req_n = 4'b1001; busy_n = 1'b1;
    step();
    chk("R4 pointer from 2 picks 1", g_rr, 4'b1101);
    req_n = 4'hF;
    rst_n = 1'b0;
    #1;
    chk_all("R1 async reset", 4'hF, 4'hF, 4'hF);
    step();
    rst_n = 1'b1;
    drive(4'b1001, 1'b1);
    chk("R1 pointer back at 3", g_rr, 4'b1011);
    drive(4'hF, 1'b1);
  endtask

  initial begin
    t_reset();
    t_grant_rotate();
    t_bus_clear();
    t_drop_idle();
    t_reset_pointer();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule